// File: doc/BRIEF.md
# Fixed-Priority Shared-Bus Arbiter with Lock and Split Handling

This block decides which of up to sixteen master slots may drive the address bus of a shared pipelined bus. Slot 0 is a dummy that only ever issues idle transfers, so slots 1 and up hold the real masters. Each cycle the arbiter looks at the requests, the lock inputs, the transfer kind and burst code on the bus, the slave response and ready, and a per-slot split-release vector. It then registers a one-hot grant. Ownership, reported as an owner number and an owner-locked flag, moves to the granted slot only on a cycle where the bus is ready.

Among the eligible requesters, the lowest-numbered one wins. When nobody is eligible, a parameter selects the default slot. A defined-length burst keeps its owner until its beats are counted out. A locked sequence keeps its owner for one extra unlocked transfer. A master that received a split response is masked until the slave sets its release bit. A split or retry on a locked data phase overrides normal arbitration.

Top module: `bus_arbiter`

## Requirements
- R1: After reset the grant is one-hot on slot DEFAULT_MASTER, the owner number equals DEFAULT_MASTER and the owner-locked flag is 0.
- R2: On every clock edge the grant register moves to the lowest-numbered slot at or above 1 whose request is high and which is not split-masked. The request of slot 0 is never honoured.
- R3: When no real slot is eligible, the grant goes to DEFAULT_MASTER, which needs no request of its own. If DEFAULT_MASTER is itself split-masked, the grant goes to slot 0.
- R4: The owner number and owner-locked flag change only on edges where `xfer_ready` is 1. On such an edge the owner takes the slot that was granted just before the edge.
- R5: On a ready edge, the owner-locked flag takes the lock input of the slot that becomes owner. It is always 0 for slot 0.
- R6: Transfer kind encodes 0 idle, 1 busy, 2 first beat, 3 continuation beat. Burst codes 2/3 mean 4 beats, 4/5 mean 8 and 6/7 mean 16. When a first beat with a 4, 8 or 16 beat code is accepted, the grant stays with the owner until the next-to-last beat has been accepted. It may then move, so that the owner changes only after the last beat.
- R7: Burst codes 0 (single) and 1 (undefined length) give no hold: a higher-priority requester takes the grant on the edge that accepts the first beat.
- R8: Response encodes 0 okay, 1 error, 2 retry, 3 split. Any non-okay response cancels a burst hold, so arbitration resumes on that same edge.
- R9: While the granted slot asserts lock, or the owner-locked flag will be 1 after the edge, the grant stays on that slot. After lock drops, the locking slot remains owner for exactly one transfer with the owner-locked flag 0.
- R10: A split response in its first cycle (ready 0) masks the data-phase owner. The masked slot cannot be granted until its `split_done` bit is 1.
- R11: A retry response does not mask the master: it stays eligible, and only a higher-priority requester can take the grant from it.
- R12: A first-cycle retry on a locked data phase grants the locking slot again. A first-cycle split on a locked data phase grants slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_req | input | NUM_SLOTS | Bus request per slot |
| mst_lock | input | NUM_SLOTS | Locked-sequence request per slot |
| xfer_ready | input | 1 | Bus ready; ownership moves only when high |
| xfer_resp | input | 2 | Slave response code |
| burst_kind | input | 3 | Burst code of the current address phase |
| xfer_kind | input | 2 | Transfer kind of the current address phase |
| split_done | input | NUM_SLOTS | Per-slot release of a split mask |
| mst_grant | output | NUM_SLOTS | Registered one-hot grant |
| owner_id | output | $clog2(NUM_SLOTS) | Slot owning the address bus |
| owner_locked | output | 1 | Current address phase is locked |

## Verification
The grant is due one rising edge after the requests, responses and burst codes that select it are applied. The owner number and owner-locked flag follow one ready edge after that grant. A burst hold or a lock hold therefore shows up as the grant staying put across edges, while the owner lags the grant by one ready edge. The bench drives every input just after a falling edge, lets exactly one rising edge pass per step, and compares the outputs at the next falling edge against values it computes from the priority rule and the counted beats. Owner checks always expect the grant value from the step before.

// File: rtl/arb_pkg.sv
package arb_pkg;
   localparam int MAX_SLOTS = 16;
   localparam int MAX_BEATS = 16;
   localparam int BEAT_W    = $clog2(MAX_BEATS);

   typedef enum logic [1:0] {
      XFER_IDLE   = 2'd0,
      XFER_BUSY   = 2'd1,
      XFER_NONSEQ = 2'd2,
      XFER_SEQ    = 2'd3
   } xfer_e;

   typedef enum logic [1:0] {
      RSP_OKAY  = 2'd0,
      RSP_ERROR = 2'd1,
      RSP_RETRY = 2'd2,
      RSP_SPLIT = 2'd3
   } rsp_e;

   // beats remaining after the first one of a defined-length burst
   function automatic logic [BEAT_W-1:0] beats_after_first(input logic [2:0] code);
      logic [BEAT_W-1:0] n;
      case (code)
         3'd2, 3'd3: n = BEAT_W'(3);
         3'd4, 3'd5: n = BEAT_W'(7);
         3'd6, 3'd7: n = BEAT_W'(15);
         default:    n = '0;
      endcase
      return n;
   endfunction
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
   parameter int NUM_SLOTS = 8,
   parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS-1:0] cand,
   output logic                 found,
   output logic [IDX_W-1:0]     idx
);
   // lowest-numbered candidate wins
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/arb_burst_track.sv
module arb_burst_track
   import arb_pkg::*;
#(
   parameter int CNT_W = arb_pkg::BEAT_W
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ready,
   input  logic [1:0] kind,
   input  logic [2:0] burst,
   input  logic [1:0] resp,
   input  logic       handover,
   output logic       hold
);
   generate
      if (CNT_W < BEAT_W) begin : g_bad_width
         initial $fatal(1, "arb_burst_track: CNT_W too small for the longest burst");
      end
   endgenerate

   logic [CNT_W-1:0] left_q, left_d;

   always_comb begin
      if (resp != RSP_OKAY)
         left_d = '0;
      else if (ready && handover)
         left_d = '0;
      else if (ready && kind == XFER_NONSEQ)
         left_d = CNT_W'(beats_after_first(burst));
      else if (ready && kind == XFER_SEQ && left_q != '0)
         left_d = left_q - CNT_W'(1);
      else
         left_d = left_q;
   end

   // two or more beats still to come: the next owner sample must not move
   assign hold = (left_d >= CNT_W'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) left_q <= '0;
      else        left_q <= left_d;
   end
endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
   parameter int NUM_SLOTS = 8,
   parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic [IDX_W-1:0]     set_idx,
   input  logic [NUM_SLOTS-1:0] release_vec,
   output logic [NUM_SLOTS-1:0] mask_q,
   output logic [NUM_SLOTS-1:0] mask_next
);
   generate
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
         localparam bit CAN_SPLIT = (i != 0);
         logic hit;
         assign hit          = CAN_SPLIT && set_en && (set_idx == IDX_W'(i));
         assign mask_next[i] = (mask_q[i] && !release_vec[i]) || hit;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mask_q[i] <= 1'b0;
            else        mask_q[i] <= mask_next[i];
         end
      end
   endgenerate
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
   import arb_pkg::*;
#(
   parameter int NUM_SLOTS      = 8,
   parameter int DEFAULT_MASTER = 1,
   localparam int IDX_W         = $clog2(NUM_SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] mst_req,
   input  logic [NUM_SLOTS-1:0] mst_lock,
   input  logic                 xfer_ready,
   input  logic [1:0]           xfer_resp,
   input  logic [2:0]           burst_kind,
   input  logic [1:0]           xfer_kind,
   input  logic [NUM_SLOTS-1:0] split_done,
   output logic [NUM_SLOTS-1:0] mst_grant,
   output logic [IDX_W-1:0]     owner_id,
   output logic                 owner_locked
);
   generate
      if (NUM_SLOTS < 2 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
         initial $fatal(1, "bus_arbiter: NUM_SLOTS out of range");
      end
      if (DEFAULT_MASTER < 0 || DEFAULT_MASTER >= NUM_SLOTS) begin : g_bad_default
         initial $fatal(1, "bus_arbiter: DEFAULT_MASTER out of range");
      end
   endgenerate

   localparam logic [IDX_W-1:0] DEF_IDX = IDX_W'(DEFAULT_MASTER);
   localparam logic [NUM_SLOTS-1:0] DUMMY_BIT = NUM_SLOTS'(1);

   logic [IDX_W-1:0] grant_idx_q, grant_idx_d;
   logic [IDX_W-1:0] owner_q, owner_next, data_owner_q;
   logic             owner_locked_q, data_lock_q;
   logic             granted_lock, lock_next, hold_lock;
   logic             handover, split_first, retry_first, burst_hold;
   logic [NUM_SLOTS-1:0] mask_q, mask_next, cand;
   logic             pick_found;
   logic [IDX_W-1:0] pick_idx;

   assign handover     = xfer_ready && (grant_idx_q != owner_q);
   assign owner_next   = xfer_ready ? grant_idx_q : owner_q;
   assign granted_lock = (grant_idx_q != '0) && mst_lock[grant_idx_q];
   assign lock_next    = xfer_ready ? granted_lock : owner_locked_q;
   assign hold_lock    = lock_next || granted_lock;
   assign split_first  = !xfer_ready && (xfer_resp == RSP_SPLIT);
   assign retry_first  = !xfer_ready && (xfer_resp == RSP_RETRY);

   arb_split_mask #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_mask (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_en      (split_first),
      .set_idx     (data_owner_q),
      .release_vec (split_done),
      .mask_q      (mask_q),
      .mask_next   (mask_next)
   );

   arb_burst_track #(.CNT_W(BEAT_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .ready    (xfer_ready),
      .kind     (xfer_kind),
      .burst    (burst_kind),
      .resp     (xfer_resp),
      .handover (handover),
      .hold     (burst_hold)
   );

   assign cand = mst_req & ~mask_next & ~DUMMY_BIT;

   arb_prio_pick #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
      .cand  (cand),
      .found (pick_found),
      .idx   (pick_idx)
   );

   always_comb begin
      if (split_first && data_lock_q)
         grant_idx_d = '0;
      else if (retry_first && data_lock_q && !mask_next[data_owner_q])
         grant_idx_d = data_owner_q;
      else if (hold_lock && !mask_next[grant_idx_q])
         grant_idx_d = grant_idx_q;
      else if (burst_hold && !mask_next[owner_next])
         grant_idx_d = owner_next;
      else if (pick_found)
         grant_idx_d = pick_idx;
      else if (!mask_next[DEFAULT_MASTER])
         grant_idx_d = DEF_IDX;
      else
         grant_idx_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_idx_q    <= DEF_IDX;
         owner_q        <= DEF_IDX;
         data_owner_q   <= DEF_IDX;
         owner_locked_q <= 1'b0;
         data_lock_q    <= 1'b0;
      end else begin
         grant_idx_q <= grant_idx_d;
         if (xfer_ready) begin
            owner_q        <= grant_idx_q;
            owner_locked_q <= granted_lock;
            data_owner_q   <= owner_q;
            data_lock_q    <= owner_locked_q;
         end
      end
   end

   always_comb begin
      mst_grant              = '0;
      mst_grant[grant_idx_q] = 1'b1;
   end

   assign owner_id     = owner_q;
   assign owner_locked = owner_locked_q;
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
   parameter int NUM_SLOTS = 8,
   localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 xfer_ready,
   input logic [NUM_SLOTS-1:0] mst_lock,
   input logic [NUM_SLOTS-1:0] mst_grant,
   input logic [IDX_W-1:0]     owner_id,
   input logic                 owner_locked,
   input logic                 burst_hold,
   input logic [IDX_W-1:0]     owner_next,
   input logic [NUM_SLOTS-1:0] mask_q,
   input logic                 split_first,
   input logic                 retry_first,
   input logic                 data_lock_q,
   input logic [IDX_W-1:0]     data_owner_q
);
   logic [IDX_W-1:0] gidx;
   always_comb begin
      gidx = '0;
      for (int i = 0; i < NUM_SLOTS; i++)
         if (mst_grant[i]) gidx = IDX_W'(i);
   end

   // R4: ownership frozen while the bus is waited
   assert_owner_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_ready |=> ($stable(owner_id) && $stable(owner_locked)));

   // R4: on a ready edge ownership takes the slot granted before it
   assert_owner_follows_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ready |=> (owner_id == $past(gidx)));

   // R5: locked flag comes from the lock input of the incoming owner
   assert_lock_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ready |=> (owner_locked == ($past(gidx) != '0 && $past(mst_lock[gidx]))));

   // R6: a counted burst keeps the grant on the owner
   assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      burst_hold |=> (gidx == $past(owner_next)));

   // R10: a masked slot is never the granted one
   assert_split_excluded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_grant & mask_q) == '0);

   // R12: split on a locked data phase hands the bus to the dummy slot
   assert_locked_split_dummy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (split_first && data_lock_q) |=> mst_grant[0]);

   // R12: retry on a locked data phase regrants the locking slot
   assert_locked_retry_keep_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_first && data_lock_q) |=> (gidx == $past(data_owner_q)));
endmodule

bind bus_arbiter bus_arbiter_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .xfer_ready   (xfer_ready),
   .mst_lock     (mst_lock),
   .mst_grant    (mst_grant),
   .owner_id     (owner_id),
   .owner_locked (owner_locked),
   .burst_hold   (burst_hold),
   .owner_next   (owner_next),
   .mask_q       (mask_q),
   .split_first  (split_first),
   .retry_first  (retry_first),
   .data_lock_q  (data_lock_q),
   .data_owner_q (data_owner_q)
);

// File: tb/bus_arbiter_bench.sv
`timescale 1ns/1ps
module bus_arbiter_bench;
   localparam int N   = 4;
   localparam int DEF = 2;
   localparam int IW  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  mst_req = '0, mst_lock = '0, split_done = '0;
   logic          xfer_ready = 1'b1;
   logic [1:0]    xfer_resp = 2'd0, xfer_kind = 2'd0;
   logic [2:0]    burst_kind = 3'd0;
   logic [N-1:0]  mst_grant;
   logic [IW-1:0] owner_id;
   logic          owner_locked;

   int vectors = 0;
   int miscompares = 0;

   always #2.5 clk = ~clk;

   bus_arbiter #(.NUM_SLOTS(N), .DEFAULT_MASTER(DEF)) u_bus_arbiter (
      .clk(clk), .rst_n(rst_n), .mst_req(mst_req), .mst_lock(mst_lock),
      .xfer_ready(xfer_ready), .xfer_resp(xfer_resp), .burst_kind(burst_kind),
      .xfer_kind(xfer_kind), .split_done(split_done), .mst_grant(mst_grant),
      .owner_id(owner_id), .owner_locked(owner_locked)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_grant(input string tag, input int exp);
      logic [N-1:0] e;
      e = N'(1 << exp);
      vectors++;
      if (mst_grant !== e) begin
         miscompares++;
         $display("FAIL %s grant actual=%b expected=%b", tag, mst_grant, e);
      end
   endtask

   task automatic chk_owner(input string tag, input int exp);
      vectors++;
      if (owner_id !== IW'(exp)) begin
         miscompares++;
         $display("FAIL %s owner actual=%0d expected=%0d", tag, owner_id, exp);
      end
   endtask

   task automatic chk_lock(input string tag, input logic exp);
      vectors++;
      if (owner_locked !== exp) begin
         miscompares++;
         $display("FAIL %s locked actual=%b expected=%b", tag, owner_locked, exp);
      end
   endtask

   function automatic int pick(input logic [N-1:0] r, input logic [N-1:0] m);
      for (int i = 1; i < N; i++)
         if (r[i] && !m[i]) return i;
      if (!m[DEF]) return DEF;
      return 0;
   endfunction

   task automatic quiet_bus();
      xfer_ready = 1'b1; xfer_resp = 2'd0; xfer_kind = 2'd0;
      burst_kind = 3'd0; split_done = '0;
   endtask

   task automatic take_owner(input int m);
      quiet_bus();
      mst_lock = '0;
      mst_req  = N'(1 << m);
      step(); step(); step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int prev;
      int e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk_grant("R1", DEF);
      chk_owner("R1", DEF);
      chk_lock("R1", 1'b0);

      // R2 R3 R4: sweep every request pattern on an idle, ready bus
      prev = DEF;
      for (int p = 0; p < 16; p++) begin
         mst_req = N'(p);
         step();
         e = pick(N'(p), '0);
         chk_grant((p == 0) ? "R3" : "R2", e);
         chk_owner("R4", prev);
         chk_lock("R5", 1'b0);
         prev = e;
      end

      // R4: waited bus freezes ownership
      mst_req = 4'b1000; xfer_ready = 1'b0;
      step(); chk_grant("R2", 3);
      step(); step();
      chk_owner("R4", 1);
      xfer_ready = 1'b1;
      step(); chk_owner("R4", 3);

      // R5 R9: locked sequence by slot 3 against higher-priority slot 1
      take_owner(3);
      mst_lock = 4'b1000; mst_req = 4'b1010;
      step(); chk_grant("R9", 3); chk_lock("R5", 1'b1);
      step(); chk_grant("R9", 3); chk_owner("R9", 3); chk_lock("R5", 1'b1);
      mst_lock = '0;
      step(); chk_grant("R9", 1); chk_owner("R9", 3); chk_lock("R9", 1'b0);
      step(); chk_owner("R9", 1);

      // R6: 4-beat burst by slot 3 with waits in the middle
      take_owner(3);
      mst_req = 4'b1010; xfer_kind = 2'd2; burst_kind = 3'd3;
      step(); chk_grant("R6", 3);
      xfer_kind = 2'd3;
      step(); chk_grant("R6", 3);
      xfer_ready = 1'b0;
      step(); step(); chk_grant("R6", 3); chk_owner("R6", 3);
      xfer_ready = 1'b1;
      step(); chk_grant("R6", 1); chk_owner("R6", 3);
      step(); chk_owner("R6", 1);

      // R7: undefined-length burst is not held
      take_owner(3);
      mst_req = 4'b1010; xfer_kind = 2'd2; burst_kind = 3'd1;
      step(); chk_grant("R7", 1);
      // R7: single transfer is not held
      take_owner(3);
      mst_req = 4'b1010; xfer_kind = 2'd2; burst_kind = 3'd0;
      step(); chk_grant("R7", 1);

      // R8: error response ends the hold of an 8-beat burst
      take_owner(3);
      mst_req = 4'b1010; xfer_kind = 2'd2; burst_kind = 3'd5;
      step(); chk_grant("R6", 3);
      xfer_kind = 2'd3; xfer_resp = 2'd1; xfer_ready = 1'b0;
      step(); chk_grant("R8", 1);
      xfer_ready = 1'b1; xfer_kind = 2'd0;
      step();

      // R10: split masks slot 3 until released; default takes over
      take_owner(3);
      xfer_resp = 2'd3; xfer_ready = 1'b0;
      step(); chk_grant("R10", DEF);
      xfer_ready = 1'b1;
      step(); xfer_resp = 2'd0;
      step(); step(); chk_grant("R10", DEF);
      split_done = 4'b1000;
      step(); chk_grant("R10", 3);
      split_done = '0;

      // R3 R10: default slot split with no requesters leaves only the dummy
      take_owner(2);
      mst_req = '0; xfer_resp = 2'd3; xfer_ready = 1'b0;
      step(); chk_grant("R3", 0);
      xfer_ready = 1'b1;
      step(); xfer_resp = 2'd0;
      step(); chk_grant("R10", 0);
      split_done = 4'b0100;
      step(); chk_grant("R10", DEF);
      split_done = '0;

      // R11: retry does not mask
      take_owner(3);
      mst_req = 4'b1010; xfer_resp = 2'd2; xfer_ready = 1'b0;
      step(); chk_grant("R11", 1);
      mst_req = 4'b1000; xfer_ready = 1'b1;
      step(); chk_grant("R11", 3);
      xfer_resp = 2'd0;
      step();

      // R12: responses on a locked data phase
      take_owner(3);
      mst_lock = 4'b1000;
      step(); step(); chk_lock("R5", 1'b1);
      mst_req = 4'b1010; xfer_resp = 2'd2; xfer_ready = 1'b0;
      step(); chk_grant("R12", 3);
      xfer_ready = 1'b1;
      step();
      xfer_resp = 2'd3; xfer_ready = 1'b0;
      step(); chk_grant("R12", 0);
      xfer_ready = 1'b1;
      step();
      xfer_resp = 2'd0; mst_lock = '0; split_done = 4'b1000;
      step();
      split_done = '0; mst_req = 4'b1000;
      step(); chk_grant("R10", 3);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule